// File: doc/BRIEF.md
# JTAG Register Access Bridge

This block sits behind a four-wire test port and turns data-register scans into reads and writes on a simple on-chip register bus. It contains a complete TAP controller and a 4-bit instruction register. It also holds three data registers: a 40-bit access frame, a small chain-select register and a one-bit bypass stage. A debug host loads the access instruction and selects chain 0. It then shifts frames that carry a 32-bit data word, a register address and a direction flag.

Writes reach the bus in the Update-DR state of the same scan. Reads take two scans. The first scan only records the address. The bus read happens at the Capture-DR of the following scan, and the data shifts out during that scan. To read a register that has side effects without reading it twice, the host ends a read sequence with a read of address 0, which is a harmless identification word.

Top module: `jtag_reg_bridge`

## Requirements
- R1: The TAP state machine advances on the rising edge of `tck` through the sixteen standard states. `trst_n` low forces Test-Logic-Reset asynchronously. Five consecutive rising edges with `tms` high reach Test-Logic-Reset from any state.
- R2: The 4-bit instruction register loads the bypass code 4'hF in Test-Logic-Reset. It captures the pattern 4'b0001 in Capture-IR, shifts LSB first, and takes the shifted value in Update-IR.
- R3: Instruction 4'hC selects the 40-bit access frame. It shifts LSB first: bits 31:0 hold the data word (sent first), bits 38:32 hold the register address, and bit 39 holds the direction flag.
- R4: When the flag is 1, `bus_we` is high for exactly the one `tck` cycle spent in Update-DR. During that cycle `bus_addr` and `bus_wdata` carry the scanned address and data.
- R5: When the flag is 0, Update-DR records the address as a pending read. At the next Capture-DR under the access instruction, `bus_re` is high for one cycle and the frame loads `{8'h00, bus_rdata}`. With no pending read, the frame captures all zeros.
- R6: Each posted read produces exactly one `bus_re`, so ending a sequence with a read of address 0 adds no second access to a register with read side effects.
- R7: Instruction 4'h2 selects a 4-bit chain-select register. It captures the active chain number and loads the shifted value at Update-DR. Only `trst_n` resets the chain to 0.
- R8: Bus strobes occur only while the instruction is 4'hC and the active chain is 0. Otherwise writes are dropped, and a pending read is kept until a later capture on chain 0.
- R9: Any other instruction selects a one-bit bypass stage that captures 0, giving a one-cycle delay from `tdi` to `tdo`.
- R10: `tdo` and `tdo_oe` change on the falling edge of `tck`. `tdo_oe` is high only while the state is Shift-DR or Shift-IR, and `tdo` is 0 whenever `tdo_oe` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, changes on falling edge |
| tdo_oe | output | 1 | High while `tdo` is being driven |
| bus_addr | output | 7 | Register address |
| bus_wdata | output | 32 | Write data |
| bus_we | output | 1 | One-cycle write strobe |
| bus_re | output | 1 | One-cycle read strobe |
| bus_rdata | input | 32 | Read data, returned in the same cycle |

## Verification
The hardest case to reach is a read that is still pending when the host switches to a different chain and scans under the access instruction. Because the read is deferred across scans, the bus must stay idle, and the read must later complete with the correct data. The stimulus posts a read, switches chains through the chain-select instruction, and scans a write and a read that must both be dropped. It then returns to chain 0 and checks that the next frame shifts out the word from the originally posted address. A bench-side counter of reads of one side-effect register confirms that the trailing read of address 0 adds no second access.

// File: rtl/jrb_pkg.sv
`timescale 1ns/1ps
package jrb_pkg;

   typedef enum logic [3:0] {
      ST_RESET  = 4'hF,
      ST_IDLE   = 4'hC,
      ST_SEL_DR = 4'h7,
      ST_CAP_DR = 4'h6,
      ST_SH_DR  = 4'h2,
      ST_EX1_DR = 4'h1,
      ST_PA_DR  = 4'h3,
      ST_EX2_DR = 4'h0,
      ST_UPD_DR = 4'h5,
      ST_SEL_IR = 4'h4,
      ST_CAP_IR = 4'hE,
      ST_SH_IR  = 4'hA,
      ST_EX1_IR = 4'h9,
      ST_PA_IR  = 4'hB,
      ST_EX2_IR = 4'h8,
      ST_UPD_IR = 4'hD
   } tap_state_e;

   function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
      tap_state_e n;
      case (s)
         ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
         ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
         ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
         ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
         ST_EX1_DR: n = m ? ST_UPD_DR : ST_PA_DR;
         ST_PA_DR:  n = m ? ST_EX2_DR : ST_PA_DR;
         ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
         ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
         ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
         ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
         ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
         ST_EX1_IR: n = m ? ST_UPD_IR : ST_PA_IR;
         ST_PA_IR:  n = m ? ST_EX2_IR : ST_PA_IR;
         ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
         ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
         default:   n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/jrb_tap_fsm.sv
`timescale 1ns/1ps
module jrb_tap_fsm
   import jrb_pkg::*;
(
   input  logic       tck,
   input  logic       trst_n,
   input  logic       tms,
   output tap_state_e state
);

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) state <= ST_RESET;
      else         state <= tap_next(state, tms);
   end

endmodule

// File: rtl/jrb_instr_reg.sv
`timescale 1ns/1ps
module jrb_instr_reg
   import jrb_pkg::*;
#(
   parameter int            IR_W     = 4,
   parameter logic [IR_W-1:0] IR_RESET = '1
) (
   input  logic            tck,
   input  logic            trst_n,
   input  tap_state_e      state,
   input  logic            tdi,
   output logic [IR_W-1:0] ir_q,
   output logic            ir_so
);

   localparam logic [IR_W-1:0] CAPTURE_PAT = IR_W'(1);

   logic [IR_W-1:0] sr;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr   <= '0;
         ir_q <= IR_RESET;
      end else begin
         case (state)
            ST_RESET:  ir_q <= IR_RESET;
            ST_CAP_IR: sr   <= CAPTURE_PAT;
            ST_SH_IR:  sr   <= {tdi, sr[IR_W-1:1]};
            ST_UPD_IR: ir_q <= sr;
            default: ;
         endcase
      end
   end

   assign ir_so = sr[0];

endmodule

// File: rtl/jrb_access_dr.sv
`timescale 1ns/1ps
module jrb_access_dr
   import jrb_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 7
) (
   input  logic              tck,
   input  logic              trst_n,
   input  tap_state_e        state,
   input  logic              tdi,
   input  logic              ir_hit,
   input  logic              chain_ok,
   input  logic [DATA_W-1:0] bus_rdata,
   output logic              acc_so,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re
);

   localparam int FRAME_W = DATA_W + ADDR_W + 1;
   localparam int FLAG_B  = FRAME_W - 1;

   logic [FRAME_W-1:0] sr;
   logic [ADDR_W-1:0]  pend_addr;
   logic               pend_vld;
   logic [ADDR_W-1:0]  f_addr;
   logic               f_wr;
   logic               live;

   assign f_addr = sr[DATA_W +: ADDR_W];
   assign f_wr   = sr[FLAG_B];
   assign live   = ir_hit && chain_ok;

   assign bus_we    = live && (state == ST_UPD_DR) && f_wr;
   assign bus_re    = live && (state == ST_CAP_DR) && pend_vld;
   assign bus_addr  = bus_we ? f_addr : pend_addr;
   assign bus_wdata = sr[DATA_W-1:0];
   assign acc_so    = sr[0];

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr        <= '0;
         pend_addr <= '0;
         pend_vld  <= 1'b0;
      end else if (ir_hit) begin
         case (state)
            ST_CAP_DR: begin
               sr <= bus_re ? FRAME_W'(bus_rdata) : '0;
               if (bus_re) pend_vld <= 1'b0;
            end
            ST_SH_DR: sr <= {tdi, sr[FRAME_W-1:1]};
            ST_UPD_DR: begin
               if (chain_ok && !f_wr) begin
                  pend_addr <= f_addr;
                  pend_vld  <= 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/jrb_select_dr.sv
`timescale 1ns/1ps
module jrb_select_dr
   import jrb_pkg::*;
#(
   parameter int               CHAIN_W     = 4,
   parameter logic [CHAIN_W-1:0] CHAIN_RESET = '0
) (
   input  logic               tck,
   input  logic               trst_n,
   input  tap_state_e         state,
   input  logic               tdi,
   input  logic               chain_hit,
   input  logic               byp_hit,
   output logic [CHAIN_W-1:0] chain_q,
   output logic               chain_so,
   output logic               byp_so
);

   logic [CHAIN_W-1:0] sr;
   logic               byp;

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         sr      <= '0;
         chain_q <= CHAIN_RESET;
      end else if (chain_hit) begin
         case (state)
            ST_CAP_DR: sr      <= chain_q;
            ST_SH_DR:  sr      <= {tdi, sr[CHAIN_W-1:1]};
            ST_UPD_DR: chain_q <= sr;
            default: ;
         endcase
      end
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) byp <= 1'b0;
      else if (byp_hit) begin
         if (state == ST_CAP_DR)     byp <= 1'b0;
         else if (state == ST_SH_DR) byp <= tdi;
      end
   end

   assign chain_so = sr[0];
   assign byp_so   = byp;

endmodule

// File: rtl/jtag_reg_bridge.sv
`timescale 1ns/1ps
module jtag_reg_bridge
   import jrb_pkg::*;
#(
   parameter int                 IR_W         = 4,
   parameter int                 DATA_W       = 32,
   parameter int                 ADDR_W       = 7,
   parameter int                 CHAIN_W      = 4,
   parameter logic [IR_W-1:0]    INSTR_ACCESS = 'hC,
   parameter logic [IR_W-1:0]    INSTR_CHAIN  = 'h2,
   parameter logic [IR_W-1:0]    IR_RESET     = '1,
   parameter logic [CHAIN_W-1:0] ACCESS_CHAIN = '0,
   parameter logic [CHAIN_W-1:0] CHAIN_RESET  = '0,
   parameter bit                 TDO_ON_FALL  = 1'b1
) (
   input  logic              tck,
   input  logic              trst_n,
   input  logic              tms,
   input  logic              tdi,
   output logic              tdo,
   output logic              tdo_oe,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   output logic              bus_we,
   output logic              bus_re,
   input  logic [DATA_W-1:0] bus_rdata
);

   initial begin
      if (IR_W < 2)                      $fatal(1, "IR_W too small");
      if (DATA_W < 1 || ADDR_W < 1)      $fatal(1, "frame fields must be non-empty");
      if (CHAIN_W < 1)                   $fatal(1, "CHAIN_W must be positive");
      if (INSTR_ACCESS == INSTR_CHAIN)   $fatal(1, "instruction codes collide");
      if (IR_RESET == INSTR_ACCESS)      $fatal(1, "reset instruction must not be access");
   end

   tap_state_e         tap_state;
   logic [IR_W-1:0]    ir_q;
   logic               ir_so;
   logic [CHAIN_W-1:0] chain_q;
   logic               chain_so, byp_so, acc_so;
   logic               acc_hit, chain_hit, byp_hit, chain_ok;
   logic               shift_now, so_mux;

   assign acc_hit   = (ir_q == INSTR_ACCESS);
   assign chain_hit = (ir_q == INSTR_CHAIN);
   assign byp_hit   = !acc_hit && !chain_hit;
   assign chain_ok  = (chain_q == ACCESS_CHAIN);

   jrb_tap_fsm u_fsm (
      .tck    (tck),
      .trst_n (trst_n),
      .tms    (tms),
      .state  (tap_state)
   );

   jrb_instr_reg #(.IR_W(IR_W), .IR_RESET(IR_RESET)) u_ir (
      .tck    (tck),
      .trst_n (trst_n),
      .state  (tap_state),
      .tdi    (tdi),
      .ir_q   (ir_q),
      .ir_so  (ir_so)
   );

   jrb_access_dr #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_acc (
      .tck       (tck),
      .trst_n    (trst_n),
      .state     (tap_state),
      .tdi       (tdi),
      .ir_hit    (acc_hit),
      .chain_ok  (chain_ok),
      .bus_rdata (bus_rdata),
      .acc_so    (acc_so),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re)
   );

   jrb_select_dr #(.CHAIN_W(CHAIN_W), .CHAIN_RESET(CHAIN_RESET)) u_sel (
      .tck       (tck),
      .trst_n    (trst_n),
      .state     (tap_state),
      .tdi       (tdi),
      .chain_hit (chain_hit),
      .byp_hit   (byp_hit),
      .chain_q   (chain_q),
      .chain_so  (chain_so),
      .byp_so    (byp_so)
   );

   assign shift_now = (tap_state == ST_SH_DR) || (tap_state == ST_SH_IR);

   always_comb begin
      if (tap_state == ST_SH_IR) so_mux = ir_so;
      else if (acc_hit)          so_mux = acc_so;
      else if (chain_hit)        so_mux = chain_so;
      else                       so_mux = byp_so;
   end

   logic tdo_q, oe_q;

   generate
      if (TDO_ON_FALL) begin : g_tdo_fall
         always_ff @(negedge tck or negedge trst_n) begin
            if (!trst_n) begin
               tdo_q <= 1'b0;
               oe_q  <= 1'b0;
            end else begin
               tdo_q <= shift_now ? so_mux : 1'b0;
               oe_q  <= shift_now;
            end
         end
      end else begin : g_tdo_rise
         always_ff @(posedge tck or negedge trst_n) begin
            if (!trst_n) begin
               tdo_q <= 1'b0;
               oe_q  <= 1'b0;
            end else begin
               tdo_q <= shift_now ? so_mux : 1'b0;
               oe_q  <= shift_now;
            end
         end
      end
   endgenerate

   assign tdo    = tdo_q;
   assign tdo_oe = oe_q;

endmodule

// File: rtl/jrb_checker.sv
`timescale 1ns/1ps
module jrb_checker
   import jrb_pkg::*;
#(
   parameter int                 IR_W         = 4,
   parameter int                 CHAIN_W      = 4,
   parameter logic [IR_W-1:0]    INSTR_ACCESS = 'hC,
   parameter logic [IR_W-1:0]    IR_RESET     = '1,
   parameter logic [CHAIN_W-1:0] ACCESS_CHAIN = '0,
   parameter bit                 TDO_ON_FALL  = 1'b1
) (
   input logic               tck,
   input logic               trst_n,
   input logic               tms,
   input tap_state_e         state,
   input logic [IR_W-1:0]    ir_q,
   input logic [CHAIN_W-1:0] chain_q,
   input logic               bus_we,
   input logic               bus_re,
   input logic               tdo,
   input logic               tdo_oe
);

   // R1: five high TMS samples always land in Test-Logic-Reset
   p_five_ones_r1: assert property (@(posedge tck) disable iff (!trst_n)
      (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4))
      |=> (state == ST_RESET));

   // R2: Test-Logic-Reset leaves the bypass code in the instruction register
   p_reset_bypass_r2: assert property (@(posedge tck) disable iff (!trst_n)
      (state == ST_RESET) |=> (ir_q == IR_RESET));

   // R4: write strobe is a single cycle
   p_we_single_r4: assert property (@(posedge tck) disable iff (!trst_n)
      bus_we |=> !bus_we);

   // R5: read strobe is a single cycle and never overlaps a write
   p_re_single_r5: assert property (@(posedge tck) disable iff (!trst_n)
      bus_re |=> !bus_re);
   p_strobe_excl_r5: assert property (@(posedge tck) disable iff (!trst_n)
      !(bus_we && bus_re));

   // R8: bus is silent unless access instruction on the access chain
   p_gated_r8: assert property (@(posedge tck) disable iff (!trst_n)
      !((ir_q == INSTR_ACCESS) && (chain_q == ACCESS_CHAIN)) |-> (!bus_we && !bus_re));

   // R10: output quiet when not enabled
   p_tdo_quiet_r10: assert property (@(posedge tck) disable iff (!trst_n)
      !tdo_oe |-> !tdo);

   generate
      if (TDO_ON_FALL) begin : g_oe_chk
         // R10: enable tracks shift states, updated half a cycle after entry
         p_oe_shift_r10: assert property (@(posedge tck) disable iff (!trst_n)
            tdo_oe == ((state == ST_SH_DR) || (state == ST_SH_IR)));
      end
   endgenerate

endmodule

bind jtag_reg_bridge jrb_checker #(
   .IR_W         (IR_W),
   .CHAIN_W      (CHAIN_W),
   .INSTR_ACCESS (INSTR_ACCESS),
   .IR_RESET     (IR_RESET),
   .ACCESS_CHAIN (ACCESS_CHAIN),
   .TDO_ON_FALL  (TDO_ON_FALL)
) u_chk (
   .tck     (tck),
   .trst_n  (trst_n),
   .tms     (tms),
   .state   (tap_state),
   .ir_q    (ir_q),
   .chain_q (chain_q),
   .bus_we  (bus_we),
   .bus_re  (bus_re),
   .tdo     (tdo),
   .tdo_oe  (tdo_oe)
);

// File: tb/jtag_reg_bridge_tb.sv
`timescale 1ns/1ps
module jtag_reg_bridge_tb;

   localparam logic [31:0] ID_WORD = 32'h5EC0_0A11;

   logic        tck = 1'b0;
   logic        trst_n = 1'b0;
   logic        tms = 1'b1;
   logic        tdi = 1'b0;
   logic        tdo, tdo_oe, bus_we, bus_re;
   logic [6:0]  bus_addr;
   logic [31:0] bus_wdata, bus_rdata;

   always #2 tck = ~tck;

   jtag_reg_bridge u_dut (
      .tck       (tck),
      .trst_n    (trst_n),
      .tms       (tms),
      .tdi       (tdi),
      .tdo       (tdo),
      .tdo_oe    (tdo_oe),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_we    (bus_we),
      .bus_re    (bus_re),
      .bus_rdata (bus_rdata)
   );

   // bus-side register model; address 9 counts reads as a side effect
   logic [31:0] regs [128];
   int we_cnt = 0, re_cnt = 0, hit9 = 0;

   assign bus_rdata = (bus_addr == 7'd0) ? ID_WORD : regs[bus_addr];

   always @(posedge tck) begin
      if (bus_we && bus_addr != 7'd0) regs[bus_addr] <= bus_wdata;
      if (bus_we) we_cnt <= we_cnt + 1;
      if (bus_re) re_cnt <= re_cnt + 1;
      if (bus_re && bus_addr == 7'd9) hit9 <= hit9 + 1;
   end

   int n_chk = 0, n_bad = 0, oe_bad = 0;
   bit done = 1'b0;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic tick(input logic m, input logic d, output logic o, output logic e);
      @(negedge tck);
      #1;
      o = tdo;
      e = tdo_oe;
      tms = m;
      tdi = d;
   endtask

   // from Run-Test/Idle, one IR or DR scan, back to Run-Test/Idle
   task automatic scan(input logic is_ir, input logic [63:0] v, input int n,
                       output logic [63:0] o);
      logic b, e;
      o = '0;
      tick(1'b1, 1'b0, b, e);
      if (is_ir) tick(1'b1, 1'b0, b, e);
      tick(1'b0, 1'b0, b, e);
      tick(1'b0, 1'b0, b, e);
      for (int i = 0; i < n; i++) begin
         tick(i == n - 1, v[i], b, e);
         o[i] = b;
         if (!e) oe_bad++;
      end
      tick(1'b1, 1'b0, b, e);
      tick(1'b0, 1'b0, b, e);
      tick(1'b0, 1'b0, b, e);
   endtask

   task automatic go_idle();
      logic b, e;
      for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, b, e);
      tick(1'b0, 1'b0, b, e);
      tick(1'b0, 1'b0, b, e);
   endtask

   typedef struct packed {
      logic        wr;
      logic [6:0]  addr;
      logic [31:0] data;
      logic [31:0] exp;
   } vec_t;

   localparam vec_t VEC [8] = '{
      '{1'b1, 7'd3, 32'hA1A1_0001, 32'h0},
      '{1'b1, 7'd4, 32'hB2B2_0002, 32'h0},
      '{1'b0, 7'd3, 32'h0,         32'h0},
      '{1'b0, 7'd4, 32'h0,         32'hA1A1_0001},
      '{1'b1, 7'd3, 32'hC3C3_0003, 32'hB2B2_0002},
      '{1'b0, 7'd3, 32'h0,         32'h0},
      '{1'b0, 7'd0, 32'h0,         32'hC3C3_0003},
      '{1'b0, 7'd0, 32'h0,         ID_WORD}
   };

   initial begin
      #400000;
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [63:0] o;
      int w0, r0, h0;
      for (int i = 0; i < 128; i++) regs[i] = 32'h0101_0101 * i;

      // reset state
      repeat (3) @(posedge tck);
      #1;
      check("R10 reset oe", 64'(tdo_oe), 64'd0);
      check("R4 reset we", 64'(bus_we), 64'd0);
      check("R5 reset re", 64'(bus_re), 64'd0);
      trst_n = 1'b1;
      go_idle();

      // R2: capture pattern; R9: bypass after reset gives one-cycle delay
      scan(1'b0, 64'hB, 4, o);
      check("R9 bypass delay", o[3:0], 64'h6);
      scan(1'b1, 64'hC, 4, o);
      check("R2 ir capture", o[3:0], 64'h1);
      check("R10 oe in shift", 64'(oe_bad), 64'd0);
      check("R10 oe idle", 64'(tdo_oe), 64'd0);

      // R3/R4/R5 table walk: frame = {flag, addr, data}
      foreach (VEC[k]) begin
         w0 = we_cnt;
         scan(1'b0, {24'h0, VEC[k].wr, VEC[k].addr, VEC[k].data}, 40, o);
         check("R5 R3 frame out", o[39:0], {24'h0, 8'h0, VEC[k].exp});
         check("R4 one write strobe", 64'(we_cnt - w0), 64'(VEC[k].wr));
      end

      // R6: side-effect register read once, trailing read of address 0
      scan(1'b0, {24'h0, 1'b1, 7'd9, 32'h0000_0905}, 40, o);
      check("R6 prior pending id", o[39:0], {32'h0, ID_WORD});
      h0 = hit9;
      r0 = re_cnt;
      scan(1'b0, {24'h0, 1'b0, 7'd9, 32'h0}, 40, o);
      scan(1'b0, {24'h0, 1'b0, 7'd0, 32'h0}, 40, o);
      check("R6 side reg data", o[39:0], 64'h0000_0905);
      check("R6 side reg hits", 64'(hit9 - h0), 64'd1);
      check("R6 read strobes", 64'(re_cnt - r0), 64'd1);

      // R7/R8: switch chain while a read of address 0 is pending
      scan(1'b1, 64'h2, 4, o);
      scan(1'b0, 64'h3, 4, o);
      check("R7 chain capture reset", o[3:0], 64'h0);
      scan(1'b0, 64'h3, 4, o);
      check("R7 chain capture new", o[3:0], 64'h3);
      scan(1'b1, 64'hC, 4, o);
      w0 = we_cnt;
      r0 = re_cnt;
      scan(1'b0, {24'h0, 1'b1, 7'd6, 32'hDEAD_BEEF}, 40, o);
      scan(1'b0, {24'h0, 1'b0, 7'd6, 32'h0}, 40, o);
      check("R8 no write off chain", 64'(we_cnt - w0), 64'd0);
      check("R8 no read off chain", 64'(re_cnt - r0), 64'd0);
      scan(1'b1, 64'h2, 4, o);
      scan(1'b0, 64'h0, 4, o);
      check("R7 chain readback", o[3:0], 64'h3);
      scan(1'b1, 64'hC, 4, o);
      scan(1'b0, {24'h0, 1'b0, 7'd6, 32'h0}, 40, o);
      check("R8 pending kept", o[39:0], {32'h0, ID_WORD});
      scan(1'b0, {24'h0, 1'b0, 7'd0, 32'h0}, 40, o);
      check("R8 dropped write", o[39:0], 64'h0606_0606);

      // R1/R2: five TMS highs restore bypass
      go_idle();
      scan(1'b0, 64'h9, 4, o);
      check("R1 tms reset to bypass", o[3:0], 64'h2);
      check("R10 oe total", 64'(oe_bad), 64'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule